// File: doc/BRIEF.md
# Precise Trap Controller for a Five-Stage Pipeline

This block decides, in the cycle a fault appears, how a five-stage in-order pipeline reacts to it. Decode can raise an illegal-instruction flag and execute can raise an arithmetic-overflow flag. Each flag comes with the program counter of the instruction that raised it. When a fault is taken, the block does five things in that same cycle:

- It drives flush strobes that turn the faulting instruction and every younger instruction into bubbles.
- It blocks the register write of an instruction that overflowed in execute.
- It forces the fetch PC to a handler address.
- It records the fault's PC plus the instruction size as the return address.
- It records a one-bit reason code.

Instructions already in memory access and writeback are older than the fault, so they are left to finish.

A parameter selects how the handler address is chosen. In one mode every fault goes to a single entry point. In the other mode the entry is picked by reason code, from a table of slots spaced 0x20 apart. When decode and execute both fault in the same cycle, the instruction in execute is the older of the two and is the only one reported.

Top module: `trap_unit`

## Requirements
- R1: The reason register encodes illegal instruction as 0 and overflow as 1, and it takes the value of the fault being taken on the clock edge that ends that cycle.
- R2: On the edge after a taken fault, the return-address register holds the faulting PC plus 4 (for example, a fault at 0x4C gives 0x50).
- R3: With VECTORED=0, `redirect` is high in the cycle of a taken fault and `redirect_pc` is 0x80000180 for either reason.
- R4: With VECTORED=1, `redirect_pc` is 0xC0000000 for illegal instruction and 0xC0000020 for overflow. This is the base 0xC0000000 plus the reason code times 0x20.
- R5: A valid overflow in execute raises `flush_fd`, `flush_de` and `bubble_em` in the same cycle, and it holds `ex_wen_o` low even when `ex_wen_i` is high.
- R6: A valid illegal instruction in decode with no execute fault raises `flush_fd` and `flush_de`, keeps `bubble_em` low, and passes `ex_wen_i` through to `ex_wen_o`.
- R7: When both faults are valid in the same cycle, the overflow is taken. The reason code becomes 1, the return address is derived from `ex_pc`, and all three flush strobes are high.
- R8: In a cycle with no taken fault, the return-address and reason registers keep their values, no flush or redirect is raised, and `ex_wen_o` equals `ex_wen_i`.
- R9: After a synchronous reset, the return address is 0, the reason code is 0, and no strobe is high.
- R10: A fault flag whose stage-valid input is low has no effect on any output or register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_valid | input | 1 | Decode stage holds a real instruction |
| id_illegal | input | 1 | Decode found an undefined opcode |
| id_pc | input | XLEN | PC of the instruction in decode |
| ex_valid | input | 1 | Execute stage holds a real instruction |
| ex_ovf | input | 1 | Execute result overflowed |
| ex_pc | input | XLEN | PC of the instruction in execute |
| ex_wen_i | input | 1 | Register write request of the execute instruction |
| ex_wen_o | output | 1 | Register write request after fault gating |
| flush_fd | output | 1 | Turn the fetch/decode register into a bubble |
| flush_de | output | 1 | Turn the decode/execute register into a bubble |
| bubble_em | output | 1 | Zero the controls of the execute result entering memory |
| redirect | output | 1 | Force the fetch PC this cycle |
| redirect_pc | output | XLEN | Handler address |
| epc | output | XLEN | Saved return address |
| cause | output | 1 | Saved reason code |

## Verification
The two functions that can coincide are decode's illegal-instruction report and execute's overflow report. The bench raises both in one cycle, with distinct PCs in the two stages. It then checks that the reported reason is overflow, that the saved address is the execute PC plus 4, and that the memory-stage bubble is raised. A fixed-mode instance and a vectored instance are driven from the same inputs, so the handler address chosen for the colliding faults is checked in both modes. Back-to-back faults and faults with the stage-valid input low are also driven, to confirm that the registers hold between faults and that flags from invalid stages are ignored.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic {
    RSN_ILLEGAL  = 1'b0,
    RSN_OVERFLOW = 1'b1
  } reason_e;

  typedef struct packed {
    logic    take;
    reason_e reason;
    logic    kill_ex;
  } trap_sel_t;
endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter #(
  parameter int XLEN = 32
) (
  input  logic                  id_hit,
  input  logic                  ex_hit,
  input  logic [XLEN-1:0]       id_pc,
  input  logic [XLEN-1:0]       ex_pc,
  output trap_pkg::trap_sel_t   sel,
  output logic [XLEN-1:0]       src_pc
);
  import trap_pkg::*;

  // Execute holds the older instruction, so it outranks decode.
  always_comb begin
    sel.take    = ex_hit | id_hit;
    sel.kill_ex = ex_hit;
    sel.reason  = ex_hit ? RSN_OVERFLOW : RSN_ILLEGAL;
    src_pc      = ex_hit ? ex_pc : id_pc;
  end
endmodule

// File: rtl/trap_target.sv
module trap_target #(
  parameter int              XLEN       = 32,
  parameter bit              VECTORED   = 1'b0,
  parameter logic [XLEN-1:0] FIXED_BASE = 32'h8000_0180,
  parameter logic [XLEN-1:0] VEC_BASE   = 32'hC000_0000,
  parameter logic [XLEN-1:0] VEC_STRIDE = 32'h0000_0020
) (
  input  trap_pkg::reason_e reason,
  output logic [XLEN-1:0]   target
);
  generate
    if (VECTORED) begin : g_vec
      always_comb target = VEC_BASE + (XLEN'(reason) * VEC_STRIDE);
    end else begin : g_fixed
      logic unused_reason;
      always_comb unused_reason = reason;
      always_comb target = FIXED_BASE;
    end
  endgenerate
endmodule

// File: rtl/trap_state.sv
module trap_state #(
  parameter int XLEN    = 32,
  parameter int PC_STEP = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  trap_pkg::reason_e reason,
  input  logic [XLEN-1:0]   src_pc,
  output logic [XLEN-1:0]   epc_q,
  output logic              reason_q
);
  localparam logic [XLEN-1:0] STEP = XLEN'(PC_STEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      epc_q    <= '0;
      reason_q <= 1'b0;
    end else if (take) begin
      epc_q    <= src_pc + STEP;
      reason_q <= reason;
    end
  end
endmodule

// File: rtl/trap_unit.sv
module trap_unit #(
  parameter int              XLEN       = 32,
  parameter bit              VECTORED   = 1'b0,
  parameter int              PC_STEP    = 4,
  parameter logic [XLEN-1:0] FIXED_BASE = 32'h8000_0180,
  parameter logic [XLEN-1:0] VEC_BASE   = 32'hC000_0000,
  parameter logic [XLEN-1:0] VEC_STRIDE = 32'h0000_0020
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            id_valid,
  input  logic            id_illegal,
  input  logic [XLEN-1:0] id_pc,
  input  logic            ex_valid,
  input  logic            ex_ovf,
  input  logic [XLEN-1:0] ex_pc,
  input  logic            ex_wen_i,
  output logic            ex_wen_o,
  output logic            flush_fd,
  output logic            flush_de,
  output logic            bubble_em,
  output logic            redirect,
  output logic [XLEN-1:0] redirect_pc,
  output logic [XLEN-1:0] epc,
  output logic            cause
);
  import trap_pkg::*;

  logic            id_hit, ex_hit;
  trap_sel_t       sel;
  logic [XLEN-1:0] src_pc;
  logic [XLEN-1:0] target;

  always_comb begin
    id_hit = id_valid & id_illegal;
    ex_hit = ex_valid & ex_ovf;
  end

  trap_arbiter #(.XLEN(XLEN)) u_arb (
    .id_hit(id_hit), .ex_hit(ex_hit), .id_pc(id_pc), .ex_pc(ex_pc),
    .sel(sel), .src_pc(src_pc)
  );

  trap_target #(
    .XLEN(XLEN), .VECTORED(VECTORED), .FIXED_BASE(FIXED_BASE),
    .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
  ) u_tgt (
    .reason(sel.reason), .target(target)
  );

  trap_state #(.XLEN(XLEN), .PC_STEP(PC_STEP)) u_state (
    .clk(clk), .rst(rst), .take(sel.take & ~rst), .reason(sel.reason),
    .src_pc(src_pc), .epc_q(epc), .reason_q(cause)
  );

  // Flush and redirect act in the fault cycle; no stage may advance a faulting op.
  always_comb begin
    flush_fd    = sel.take & ~rst;
    flush_de    = sel.take & ~rst;
    bubble_em   = sel.kill_ex & ~rst;
    redirect    = sel.take & ~rst;
    redirect_pc = target;
    ex_wen_o    = ex_wen_i & ~bubble_em;
  end
endmodule

// File: rtl/trap_unit_chk.sv
module trap_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            id_valid,
  input logic            id_illegal,
  input logic [XLEN-1:0] id_pc,
  input logic            ex_valid,
  input logic            ex_ovf,
  input logic [XLEN-1:0] ex_pc,
  input logic            ex_wen_i,
  input logic            ex_wen_o,
  input logic            flush_fd,
  input logic            flush_de,
  input logic            bubble_em,
  input logic            redirect,
  input logic [XLEN-1:0] epc,
  input logic            cause
);
  // R5: overflow kills the execute result and its write
  p_ovf_kill_r5: assert property (@(posedge clk) disable iff (rst)
    (ex_valid && ex_ovf) |-> (bubble_em && flush_fd && flush_de && !ex_wen_o));

  // R2 / R7: return address follows the execute PC on overflow
  p_epc_ovf_r2: assert property (@(posedge clk) disable iff (rst)
    (ex_valid && ex_ovf) |=> (epc == $past(ex_pc) + XLEN'(4) && cause));

  // R1 / R6: lone decode fault records reason 0 and spares execute
  p_illegal_r6: assert property (@(posedge clk) disable iff (rst)
    (id_valid && id_illegal && !(ex_valid && ex_ovf)) |-> (!bubble_em && ex_wen_o == ex_wen_i));

  p_illegal_cause_r1: assert property (@(posedge clk) disable iff (rst)
    (id_valid && id_illegal && !(ex_valid && ex_ovf)) |=> (!cause && epc == $past(id_pc) + XLEN'(4)));

  // R8: registers hold without a fault
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !redirect |=> ($stable(epc) && $stable(cause)));

  // R10: invalid stages raise nothing
  p_invalid_r10: assert property (@(posedge clk) disable iff (rst)
    (!ex_valid && !id_valid) |-> (!redirect && !flush_fd && !bubble_em));
endmodule

bind trap_unit trap_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst(rst), .id_valid(id_valid), .id_illegal(id_illegal),
  .id_pc(id_pc), .ex_valid(ex_valid), .ex_ovf(ex_ovf), .ex_pc(ex_pc),
  .ex_wen_i(ex_wen_i), .ex_wen_o(ex_wen_o), .flush_fd(flush_fd),
  .flush_de(flush_de), .bubble_em(bubble_em), .redirect(redirect),
  .epc(epc), .cause(cause)
);

// File: tb/trap_unit_test.sv
module trap_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        id_valid = 0, id_illegal = 0, ex_valid = 0, ex_ovf = 0, ex_wen_i = 0;
  logic [31:0] id_pc = '0, ex_pc = '0;
  logic        ex_wen_o, flush_fd, flush_de, bubble_em, redirect, cause;
  logic [31:0] redirect_pc, epc;
  logic        v_wen, v_ffd, v_fde, v_bem, v_red, v_cause;
  logic [31:0] v_rpc, v_epc;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  trap_unit uut (
    .clk(clk), .rst(rst), .id_valid(id_valid), .id_illegal(id_illegal), .id_pc(id_pc),
    .ex_valid(ex_valid), .ex_ovf(ex_ovf), .ex_pc(ex_pc), .ex_wen_i(ex_wen_i),
    .ex_wen_o(ex_wen_o), .flush_fd(flush_fd), .flush_de(flush_de), .bubble_em(bubble_em),
    .redirect(redirect), .redirect_pc(redirect_pc), .epc(epc), .cause(cause)
  );

  trap_unit #(.VECTORED(1'b1)) uut_v (
    .clk(clk), .rst(rst), .id_valid(id_valid), .id_illegal(id_illegal), .id_pc(id_pc),
    .ex_valid(ex_valid), .ex_ovf(ex_ovf), .ex_pc(ex_pc), .ex_wen_i(ex_wen_i),
    .ex_wen_o(v_wen), .flush_fd(v_ffd), .flush_de(v_fde), .bubble_em(v_bem),
    .redirect(v_red), .redirect_pc(v_rpc), .epc(v_epc), .cause(v_cause)
  );

  typedef struct {
    string       req;
    logic        ffd, fde, bem, wen, red;
    logic [31:0] rpc, rpc_v, epc;
    logic        cause;
  } exp_t;

  exp_t        sb[$];
  logic [31:0] m_epc = '0;
  logic        m_cause = 1'b0;

  task automatic cmp(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Driver: apply one cycle of stimulus and predict the outcome from the requirements.
  task automatic drive(string req, logic iv, logic ii, logic [31:0] ipc,
                       logic ev, logic eo, logic [31:0] epc_in, logic we);
    exp_t e;
    logic ovf_t, ill_t;
    @(negedge clk);
    id_valid = iv; id_illegal = ii; id_pc = ipc;
    ex_valid = ev; ex_ovf = eo; ex_pc = epc_in; ex_wen_i = we;
    ovf_t = ev & eo;
    ill_t = iv & ii;
    e.req   = req;
    e.ffd   = ovf_t | ill_t;
    e.fde   = ovf_t | ill_t;
    e.bem   = ovf_t;
    e.wen   = we & ~ovf_t;
    e.red   = ovf_t | ill_t;
    e.rpc   = 32'h8000_0180;
    e.rpc_v = ovf_t ? 32'hC000_0020 : 32'hC000_0000;
    if (ovf_t) begin
      m_epc = epc_in + 32'd4; m_cause = 1'b1;
    end else if (ill_t) begin
      m_epc = ipc + 32'd4; m_cause = 1'b0;
    end
    e.epc   = m_epc;
    e.cause = m_cause;
    sb.push_back(e);
  endtask

  // Monitor: fault-cycle strobes just before the edge, registers just after it.
  initial begin
    forever begin
      exp_t e;
      @(negedge clk);
      #8;
      if (sb.size() != 0) begin
        e = sb.pop_front();
        cmp(e.req, "flush_fd", flush_fd, e.ffd);
        cmp(e.req, "flush_de", flush_de, e.fde);
        cmp(e.req, "bubble_em", bubble_em, e.bem);
        cmp(e.req, "ex_wen_o", ex_wen_o, e.wen);
        cmp(e.req, "redirect", redirect, e.red);
        if (e.red) begin
          cmp(e.req, "redirect_pc fixed R3", redirect_pc, e.rpc);
          cmp(e.req, "redirect_pc vectored R4", v_rpc, e.rpc_v);
        end
        @(posedge clk);
        #2;
        cmp(e.req, "epc", epc, e.epc);
        cmp(e.req, "cause", {31'd0, cause}, {31'd0, e.cause});
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    drive("R9 reset",           0, 0, 32'h0,   0, 0, 32'h0,   0);
    drive("R2 R5 R1 overflow",  0, 0, 32'h0,   1, 1, 32'h4C,  1);
    drive("R8 hold",            1, 0, 32'h50,  1, 0, 32'h4C,  1);
    drive("R6 R1 illegal",      1, 1, 32'h100, 1, 0, 32'hFC,  1);
    drive("R8 hold idle",       0, 0, 32'h0,   0, 0, 32'h0,   0);
    drive("R7 both",            1, 1, 32'h204, 1, 1, 32'h200, 1);
    drive("R10 invalid flags",  0, 1, 32'h300, 0, 1, 32'h2FC, 1);
    drive("R8 plain write",     1, 0, 32'h400, 1, 0, 32'h3FC, 1);
    drive("R5 ovf no write",    0, 0, 32'h0,   1, 1, 32'h500, 0);
    drive("R6 illegal back",    1, 1, 32'h600, 0, 0, 32'h0,   0);
    drive("R7 both again",      1, 1, 32'h704, 1, 1, 32'h700, 0);
    drive("R10 ex invalid",     1, 0, 32'h800, 0, 1, 32'h7FC, 1);
    drive("R9 idle tail",       0, 0, 32'h0,   0, 0, 32'h0,   0);
    wait (sb.size() == 0);
    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule